// File: doc/BRIEF.md
# Serial Clock Hold-Gating Controller

This block pauses a serial memory slave's command, address and data shift sequence while a host keeps an active-low hold request asserted. It samples chip select, the serial clock and the hold request in a faster system clock domain. Each of the three passes through a two-flop synchronizer before the block looks at it. From these it derives per-edge enables for the shift logic, a hold-active flag, a request to float the serial data output, a restart pulse for the shifter, and a bit position within the current 2^BIT_W-bit group.

The hold state changes only at points where the synchronized serial clock is low. A hold request that moves while the clock is low takes effect at once. A request that moves while the clock is high waits until the clock has fallen. While hold is active, serial clock edges are swallowed. The bit position therefore freezes, and it continues from the same value after release. Deselecting the device drops hold and resets the sequence. Long internal program or erase work is not affected by any of this and happens elsewhere.

Top module: `sck_hold_gate`

## Requirements
- R1: During synchronous reset (rst_n low at a clk rising edge), the outputs become hold_active=0, so_hiz=1, sck_rise_en=0, sck_fall_en=0, seq_restart=0 and bit_pos=0.
- R2: With the device selected (cs_n_in low) and sck_in low, a fall of hold_n_in makes hold_active 1 exactly three clk rising edges after the change: two synchronizer edges and one state edge.
- R3: If hold_n_in falls while sck_in is high, hold_active stays 0 for as long as sck_in stays high. It becomes 1 on the third clk edge after sck_in falls.
- R4: With sck_in low, a rise of hold_n_in clears hold_active on the third clk edge after the change.
- R5: If hold_n_in rises while sck_in is high, hold_active stays 1 for as long as sck_in stays high. It clears on the third clk edge after sck_in falls.
- R6: While hold_active is 1, sck_rise_en and sck_fall_en stay 0 and bit_pos does not change.
- R7: sck_rise_en pulses for one clk cycle for each synchronized rising serial clock edge seen while selected and not held. sck_fall_en does the same for falling edges. bit_pos counts the rising pulses modulo 2^BIT_W and resumes from its frozen value after a hold.
- R8: so_hiz is 1 whenever hold is active or the synchronized chip select is high, and 0 otherwise.
- R9: A synchronized rise of chip select gives a one-cycle seq_restart pulse. On the next clk edge, hold_active is cleared and bit_pos returns to 0.
- R10: While chip select is high, hold_n_in is ignored and hold_active stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous chip select, active low |
| sck_in | input | 1 | Asynchronous serial clock |
| hold_n_in | input | 1 | Asynchronous hold request, active low |
| hold_active | output | 1 | Hold state is in force |
| so_hiz | output | 1 | Serial data output must be high impedance |
| sck_rise_en | output | 1 | Gated enable for a rising serial clock edge |
| sck_fall_en | output | 1 | Gated enable for a falling serial clock edge |
| seq_restart | output | 1 | One-cycle pulse that restarts the shift sequence |
| bit_pos | output | BIT_W | Bit position within the current shift group |

## Verification
Hold requests are driven both in step with the serial clock, with the clock low at the request edge, and out of step, with the clock high at the request edge. The in-step runs measure the fixed three-edge latency. The out-of-step runs show that the change waits for the clock to fall. Serial clock pulses given during hold, before it and after it show whether edges are swallowed and whether the bit position picks up where it stopped. Raising chip select during hold, and toggling hold while deselected, separates a proper sequence restart from a hold that leaks in or survives deselection.

// File: rtl/hold_pkg.sv
// Package: shared constants and types for the hold-gating controller.
// Assumes: channel order cs, sck, hold in every synchronized vector.
package hold_pkg;
    localparam int CH_N    = 3;
    localparam int CH_CS   = 0;
    localparam int CH_SCK  = 1;
    localparam int CH_HOLD = 2;
    // Idle levels: deselected, clock low, hold released.
    localparam logic [CH_N-1:0] CH_IDLE = 3'b101;

    typedef enum logic {
        HG_RUN    = 1'b0,
        HG_PAUSED = 1'b1
    } hold_st_e;
endpackage

// File: rtl/hg_sync2.sv
// Module: two-flop synchronizer, one chain per bit.
// Assumes: inputs are asynchronous to clk; RST_VAL gives each bit's idle level.
module hg_sync2 #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_chain
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[gi];
                    stab_q <= RST_VAL[gi];
                end else begin
                    meta_q <= d_async[gi];
                    stab_q <= meta_q;
                end
            end
            assign q_sync[gi] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/hg_prev.sv
// Module: one-cycle delay of synchronized levels, used for edge detection.
// Assumes: RST_VAL matches the synchronizer idle levels, so no edge appears at reset.
module hg_prev #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);
    // Hold last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= RST_VAL;
        else        lvl_prev <= lvl;
    end
endmodule

// File: rtl/hg_hold_fsm.sv
// Module: hold state, updated only at synchronized serial-clock-low points.
// Assumes: all inputs are synchronized; cs_s is active high = deselected.
module hg_hold_fsm
    import hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic held
);
    hold_st_e st_q, st_d;

    // Next state: deselect clears, clock-low samples the request, clock-high keeps.
    always_comb begin
        st_d = st_q;
        if (cs_s)            st_d = HG_RUN;
        else if (!sck_s)     st_d = hold_n_s ? HG_RUN : HG_PAUSED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HG_RUN;
        else        st_q <= st_d;
    end

    assign held = (st_q == HG_PAUSED);
endmodule

// File: rtl/hg_bitpos.sv
// Module: position counter within a shift group; wraps modulo 2^BIT_W.
// Assumes: step is already gated by hold; clear has priority.
module hg_bitpos #(
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [BIT_W-1:0] pos
);
    localparam logic [BIT_W-1:0] ONE = BIT_W'(1);

    // Advance on each gated rising edge, restart on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)     pos <= '0;
        else if (clear) pos <= '0;
        else if (step)  pos <= pos + ONE;
    end
endmodule

// File: rtl/sck_hold_gate.sv
// Module: top of the hold-gating controller. It synchronizes chip select, serial
// clock and hold, keeps the hold state, gates the serial clock edge enables and
// tracks the bit position.
// Assumes: clk is at least several times faster than sck_in; outputs are
// combinational from registers.
module sck_hold_gate
    import hold_pkg::*;
#(
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_in,
    input  logic             sck_in,
    input  logic             hold_n_in,
    output logic             hold_active,
    output logic             so_hiz,
    output logic             sck_rise_en,
    output logic             sck_fall_en,
    output logic             seq_restart,
    output logic [BIT_W-1:0] bit_pos
);
    localparam int               EDGE_N   = 2;
    localparam logic [EDGE_N-1:0] EDGE_IDLE = CH_IDLE[EDGE_N-1:0];

    logic [CH_N-1:0]   raw_vec;
    logic [CH_N-1:0]   syn_vec;
    logic [EDGE_N-1:0] prev_vec;
    logic              cs_s;
    logic              sck_s;
    logic              hold_n_s;
    logic              held;
    logic              sck_up;
    logic              sck_dn;

    assign raw_vec[CH_CS]   = cs_n_in;
    assign raw_vec[CH_SCK]  = sck_in;
    assign raw_vec[CH_HOLD] = hold_n_in;

    hg_sync2 #(.WIDTH(CH_N), .RST_VAL(CH_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (syn_vec)
    );

    assign cs_s     = syn_vec[CH_CS];
    assign sck_s    = syn_vec[CH_SCK];
    assign hold_n_s = syn_vec[CH_HOLD];

    hg_prev #(.WIDTH(EDGE_N), .RST_VAL(EDGE_IDLE)) u_prev (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (syn_vec[EDGE_N-1:0]),
        .lvl_prev (prev_vec)
    );

    hg_hold_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .hold_n_s (hold_n_s),
        .held     (held)
    );

    // Serial clock edges and gating by selection and hold.
    always_comb begin
        sck_up      = sck_s & ~prev_vec[CH_SCK];
        sck_dn      = ~sck_s & prev_vec[CH_SCK];
        sck_rise_en = sck_up & ~held & ~cs_s;
        sck_fall_en = sck_dn & ~held & ~cs_s;
        seq_restart = cs_s & ~prev_vec[CH_CS];
        so_hiz      = held | cs_s;
        hold_active = held;
    end

    hg_bitpos #(.BIT_W(BIT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cs_s),
        .step  (sck_rise_en),
        .pos   (bit_pos)
    );
endmodule

// File: rtl/sck_hold_gate_chk.sv
// Module: assertion checker for sck_hold_gate, attached by bind.
// Assumes: cs_s and sck_s are the top's synchronized chip select and clock.
module sck_hold_gate_chk #(
    parameter int BIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_active,
    input logic             so_hiz,
    input logic             sck_rise_en,
    input logic             sck_fall_en,
    input logic             seq_restart,
    input logic [BIT_W-1:0] bit_pos,
    input logic             cs_s,
    input logic             sck_s
);
    // R8: the output floats whenever hold is active.
    p_hiz_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> so_hiz);

    // R6: no clock enables pass while hold is active.
    p_no_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!sck_rise_en && !sck_fall_en));

    // R6: the position is frozen across a held cycle.
    p_pos_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !seq_restart && !cs_s) |=> $stable(bit_pos));

    // R9: a restart leaves hold cleared and the position at zero.
    p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart |=> (!hold_active && bit_pos == '0));

    // R7: a rising and a falling enable never come together.
    p_one_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise_en && sck_fall_en));

    // R3 and R5: hold changes only after a clock-low sample or a deselect.
    p_hold_lowpt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_active) |-> ($past(!sck_s) || $past(cs_s)));

    // R10: no hold while deselected a cycle earlier.
    p_no_hold_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !hold_active);
endmodule

bind sck_hold_gate sck_hold_gate_chk #(.BIT_W(BIT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_active (hold_active),
    .so_hiz      (so_hiz),
    .sck_rise_en (sck_rise_en),
    .sck_fall_en (sck_fall_en),
    .seq_restart (seq_restart),
    .bit_pos     (bit_pos),
    .cs_s        (cs_s),
    .sck_s       (sck_s)
);

// File: tb/sck_hold_gate_tb.sv
// Bench: a behavioural reference model compared on every clock, plus directed checks.
module sck_hold_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BW         = 3;
    localparam int WDOG       = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n_in = 1'b1;
    logic          sck_in = 1'b0;
    logic          hold_n_in = 1'b1;
    logic          hold_active, so_hiz, sck_rise_en, sck_fall_en, seq_restart;
    logic [BW-1:0] bit_pos;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    sck_hold_gate #(.BIT_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sck_in(sck_in),
        .hold_n_in(hold_n_in), .hold_active(hold_active), .so_hiz(so_hiz),
        .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
        .seq_restart(seq_restart), .bit_pos(bit_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: input history in queues, hold and position as integers.
    int q_cs[$], q_sck[$], q_hold[$];
    int m_held, m_pos, m_kp, m_cp;

    task automatic model_reset();
        q_cs = {1, 1}; q_sck = {0, 0}; q_hold = {1, 1};
        m_held = 0; m_pos = 0; m_kp = 0; m_cp = 1;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        int c2, k2, h2, rise_old, nh;
        if (!rst_n) begin
            model_reset();
        end else begin
            c2 = q_cs[0]; k2 = q_sck[0]; h2 = q_hold[0];
            rise_old = (k2 && !m_kp && !m_held && !c2) ? 1 : 0;
            nh = c2 ? 0 : (k2 ? m_held : (h2 ? 0 : 1));
            m_pos  = c2 ? 0 : ((m_pos + rise_old) % (1 << BW));
            m_held = nh;
            m_kp = k2; m_cp = c2;
            void'(q_cs.pop_front()); void'(q_sck.pop_front()); void'(q_hold.pop_front());
            q_cs.push_back(int'(cs_n_in)); q_sck.push_back(int'(sck_in));
            q_hold.push_back(int'(hold_n_in));
            #2;
            if (rst_n && !done) begin
                chk("R2 hold_active", int'(hold_active), m_held);
                chk("R8 so_hiz", int'(so_hiz), (m_held || q_cs[0]) ? 1 : 0);
                chk("R7 sck_rise_en", int'(sck_rise_en),
                    (q_sck[0] && !m_kp && !m_held && !q_cs[0]) ? 1 : 0);
                chk("R7 sck_fall_en", int'(sck_fall_en),
                    (!q_sck[0] && m_kp && !m_held && !q_cs[0]) ? 1 : 0);
                chk("R9 seq_restart", int'(seq_restart), (q_cs[0] && !m_cp) ? 1 : 0);
                chk("R7 bit_pos", int'(bit_pos), m_pos);
            end
        end
    end

    task automatic drive(input logic cs, input logic sck, input logic hold);
        @(negedge clk);
        cs_n_in = cs; sck_in = sck; hold_n_in = hold;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic sck_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            drive(cs_n_in, 1'b1, hold_n_in); edges(3);
            drive(cs_n_in, 1'b0, hold_n_in); edges(3);
        end
    endtask

    initial begin
        edges(3);
        // R1: reset state.
        chk("R1 hold_active", int'(hold_active), 0);
        chk("R1 so_hiz", int'(so_hiz), 1);
        chk("R1 enables", int'(sck_rise_en) + int'(sck_fall_en) + int'(seq_restart), 0);
        chk("R1 bit_pos", int'(bit_pos), 0);
        @(negedge clk); rst_n = 1'b1;

        drive(1'b0, 1'b0, 1'b1); edges(4);
        sck_pulse(3);
        chk("R7 count", int'(bit_pos), 3);

        // R2: hold with clock low, three-edge latency.
        drive(1'b0, 1'b0, 1'b0); edges(2);
        chk("R2 not yet", int'(hold_active), 0);
        edges(1);
        chk("R2 entered", int'(hold_active), 1);

        // R6: pulses swallowed during hold.
        sck_pulse(2);
        chk("R6 frozen", int'(bit_pos), 3);
        chk("R8 hiz held", int'(so_hiz), 1);

        // R4: release with clock low.
        drive(1'b0, 1'b0, 1'b1); edges(2);
        chk("R4 still held", int'(hold_active), 1);
        edges(1);
        chk("R4 released", int'(hold_active), 0);
        chk("R8 driven", int'(so_hiz), 0);
        sck_pulse(2);
        chk("R7 resume", int'(bit_pos), 5);

        // R3: hold request while clock high is deferred.
        drive(1'b0, 1'b1, 1'b1); edges(3);
        drive(1'b0, 1'b1, 1'b0); edges(6);
        chk("R3 deferred", int'(hold_active), 0);
        drive(1'b0, 1'b0, 1'b0); edges(2);
        chk("R3 not yet", int'(hold_active), 0);
        edges(1);
        chk("R3 entered", int'(hold_active), 1);
        chk("R7 pos6", int'(bit_pos), 6);

        // R5: release while clock high is deferred.
        drive(1'b0, 1'b1, 1'b0); edges(3);
        drive(1'b0, 1'b1, 1'b1); edges(6);
        chk("R5 deferred", int'(hold_active), 1);
        chk("R6 no rise", int'(bit_pos), 6);
        drive(1'b0, 1'b0, 1'b1); edges(3);
        chk("R5 released", int'(hold_active), 0);

        // R9: deselect during hold.
        drive(1'b0, 1'b0, 1'b0); edges(4);
        chk("R9 pre held", int'(hold_active), 1);
        drive(1'b1, 1'b0, 1'b0); edges(3);
        chk("R9 hold cleared", int'(hold_active), 0);
        chk("R9 pos cleared", int'(bit_pos), 0);

        // R10: hold ignored while deselected.
        drive(1'b1, 1'b0, 1'b1); edges(3);
        drive(1'b1, 1'b0, 1'b0); edges(6);
        chk("R10 ignored", int'(hold_active), 0);
        sck_pulse(2);
        chk("R10 pos", int'(bit_pos), 0);

        // Reselect, release and count through a wrap.
        drive(1'b0, 1'b0, 1'b1); edges(4);
        sck_pulse(9);
        chk("R7 wrap", int'(bit_pos), 1);

        edges(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule